// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Repeat Masks

This block decides when a real-time clock alarm fires. On each one-second tick it compares the current seconds, minutes, hours and day-of-month against the programmed alarm values. A four-bit repeat mask chooses how many of those fields take part in the compare. Depending on the mask, the alarm fires once per second, once per minute, once per hour, once per day or once per month.

A match sets a sticky alarm flag. The flag stays set until software reads the flags register, which is signalled by a one-cycle read strobe. The block also drives a shared interrupt pin, modelled as a level plus an output enable. When the alarm interrupt is enabled, the pin carries the alarm flag, and it is only driven in battery mode if a separate backup enable is also set. When the alarm interrupt is disabled, the pin can carry a frequency-test clock instead, but only while main power is present. The alarm always takes priority over the frequency test on this pin.

The BCD time fields are packed into one vector, one byte per field: field 0 is seconds (bits 7:0), field 1 is minutes, field 2 is hours and field 3 is date. The alarm values are packed the same way. The block never interprets the BCD digits. It only tests each field for equality.

Top module: `alarm_match`

## Requirements
- R1: After reset, `alarmFlag` is 0. With `alarmEn` and `freqTestEn` both low, `irqOe` and `irqOut` are 0.
- R2: The compare is evaluated only in cycles where `secTick` is 1. If the compare matches, `alarmFlag` is 1 after that clock edge. A matching compare without `secTick` has no effect. The flag sets whatever the value of `alarmEn`.
- R3: `rptMask` bit 0 drops seconds, bit 1 drops minutes, bit 2 drops hours and bit 3 drops date. A mask of 4'b1111 compares no field, so every tick sets the flag.
- R4: Mask 4'b1110 compares seconds only. Mask 4'b1100 compares seconds and minutes. Mask 4'b1000 adds hours. Mask 4'b0000 compares all four fields.
- R5: Any other mask compares exactly the fields below its lowest set bit. For example, 4'b0101 compares nothing and 4'b1010 compares seconds only. This matches the nearest listed pattern that compares fewer fields.
- R6: Once set, `alarmFlag` stays 1 until a cycle with `flagsRead` = 1. It is 0 after that edge, provided no match is sampled in the same cycle.
- R7: If a sampled match and `flagsRead` occur in the same cycle, `alarmFlag` is 1 after the edge (the set wins).
- R8: With `alarmEn` = 1 and `onBattery` = 0: `irqOe` = 1 and `irqOut` equals `alarmFlag`, whatever the value of `freqTestEn`.
- R9: With `onBattery` = 1: `irqOe` = `alarmEn` AND `backupIrqEn`, and `irqOut` = `alarmFlag` when enabled. The frequency test is never driven in this mode. When `irqOe` = 0, `irqOut` = 0.
- R10: With `alarmEn` = 0, `freqTestEn` = 1 and `onBattery` = 0: `irqOe` = 1 and `irqOut` follows `freqTestClk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse per second that enables the compare |
| timeNow | input | 32 | Current BCD time, field 0 = seconds … field 3 = date |
| alarmSet | input | 32 | Programmed alarm values, same packing as `timeNow` |
| rptMask | input | 4 | Repeat mask; bit k set drops field k from the compare |
| alarmEn | input | 1 | Alarm interrupt enable |
| backupIrqEn | input | 1 | Allows the interrupt to be driven in battery mode |
| onBattery | input | 1 | Battery-backup mode indication |
| flagsRead | input | 1 | Flags-register read strobe; clears the flag |
| freqTestEn | input | 1 | Frequency-test output enable |
| freqTestClk | input | 1 | Frequency-test square wave |
| alarmFlag | output | 1 | Sticky alarm flag |
| irqOut | output | 1 | Interrupt pin level (1 = asserted) |
| irqOe | output | 1 | Interrupt pin output enable; 0 = high impedance |

## Verification
The bench builds the block with its default parameters: four fields of eight bits. This is the full seconds-to-date range with all sixteen mask values.

The time and alarm bytes are drawn from a two-value set. This makes matches, partial matches and mismatches on every field frequent. It also brings every mask, including the unlisted ones, into reach within a few thousand cycles.

A behavioural reference model predicts the flag and both pin signals every clock. Directed sequences cover the collision of a read strobe with a match and all the pin-ownership cases.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  // Strobes issued by the control toward the datapath
  typedef struct packed {
    logic sample;  // evaluate the compare this cycle
    logic clear;   // flags register is being read
  } amStrobe_t;
endpackage

// File: rtl/alarm_match_dp.sv
module alarm_match_dp
  import alarm_match_pkg::*;
#(
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  amStrobe_t                     strobe,
  input  logic [NUM_FIELDS*FIELD_W-1:0] timeNow,
  input  logic [NUM_FIELDS*FIELD_W-1:0] alarmSet,
  input  logic [NUM_FIELDS-1:0]         rptMask,
  output logic                          alarmFlag
);
  logic [NUM_FIELDS-1:0] fieldEq;
  logic [NUM_FIELDS-1:0] cmpEn;
  logic [NUM_FIELDS-1:0] fieldOk;
  logic                  matchNow;
  logic                  flagQ;

  // A field is compared only if every lower field is also compared,
  // so a mask hole drops everything above it.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
      assign fieldEq[gi] = timeNow[gi*FIELD_W +: FIELD_W] == alarmSet[gi*FIELD_W +: FIELD_W];
      if (gi == 0) begin : g_first
        assign cmpEn[gi] = ~rptMask[gi];
      end else begin : g_rest
        assign cmpEn[gi] = cmpEn[gi-1] & ~rptMask[gi];
      end
      assign fieldOk[gi] = ~cmpEn[gi] | fieldEq[gi];
    end
  endgenerate

  assign matchNow = &fieldOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strobe.sample && matchNow) begin
      flagQ <= 1'b1;
    end else if (strobe.clear) begin
      flagQ <= 1'b0;
    end
  end

  assign alarmFlag = flagQ;

  assert_set_wins_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && matchNow) |=> alarmFlag);
  assert_rise_on_tick_R2 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(strobe.sample));
  assert_sticky_R6 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(alarmFlag) |-> $past(strobe.clear));
  assert_all_masked_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && (&rptMask)) |=> alarmFlag);
endmodule

// File: rtl/alarm_match_ctrl.sv
module alarm_match_ctrl
  import alarm_match_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      secTick,
  input  logic      flagsRead,
  input  logic      alarmEn,
  input  logic      backupIrqEn,
  input  logic      onBattery,
  input  logic      freqTestEn,
  input  logic      freqTestClk,
  input  logic      alarmFlag,
  output amStrobe_t strobe,
  output logic      irqOut,
  output logic      irqOe
);
  typedef enum logic [1:0] {PIN_IDLE, PIN_ALARM, PIN_FREQ} pinOwner_e;
  pinOwner_e owner;

  always_comb begin
    strobe.sample = secTick;
    strobe.clear  = flagsRead;
  end

  // Alarm owns the pin whenever enabled; frequency test needs mains power
  always_comb begin
    if (alarmEn && (!onBattery || backupIrqEn)) begin
      owner = PIN_ALARM;
    end else if (!alarmEn && freqTestEn && !onBattery) begin
      owner = PIN_FREQ;
    end else begin
      owner = PIN_IDLE;
    end
  end

  always_comb begin
    unique case (owner)
      PIN_ALARM: begin irqOe = 1'b1; irqOut = alarmFlag;   end
      PIN_FREQ:  begin irqOe = 1'b1; irqOut = freqTestClk; end
      default:   begin irqOe = 1'b0; irqOut = 1'b0;        end
    endcase
  end

  assert_battery_quiet_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (onBattery && !(alarmEn && backupIrqEn)) |-> !irqOe);
  assert_alarm_prevails_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (alarmEn && !onBattery) |-> (irqOe && irqOut == alarmFlag));
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_match_pkg::*;
#(
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          secTick,
  input  logic [NUM_FIELDS*FIELD_W-1:0] timeNow,
  input  logic [NUM_FIELDS*FIELD_W-1:0] alarmSet,
  input  logic [NUM_FIELDS-1:0]         rptMask,
  input  logic                          alarmEn,
  input  logic                          backupIrqEn,
  input  logic                          onBattery,
  input  logic                          flagsRead,
  input  logic                          freqTestEn,
  input  logic                          freqTestClk,
  output logic                          alarmFlag,
  output logic                          irqOut,
  output logic                          irqOe
);
  amStrobe_t strobe;

  alarm_match_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .flagsRead(flagsRead),
    .alarmEn(alarmEn), .backupIrqEn(backupIrqEn), .onBattery(onBattery),
    .freqTestEn(freqTestEn), .freqTestClk(freqTestClk), .alarmFlag(alarmFlag),
    .strobe(strobe), .irqOut(irqOut), .irqOe(irqOe)
  );

  alarm_match_dp #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .timeNow(timeNow),
    .alarmSet(alarmSet), .rptMask(rptMask), .alarmFlag(alarmFlag)
  );
endmodule

// File: tb/alarm_match_tb.sv
module alarm_match_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 0, alarmEn = 0, backupIrqEn = 0, onBattery = 0;
  logic        flagsRead = 0, freqTestEn = 0, freqTestClk = 0;
  logic [31:0] timeNow = 0, alarmSet = 0;
  logic [3:0]  rptMask = 0;
  logic        alarmFlag, irqOut, irqOe;

  int checks = 0, fails = 0;
  int expFlag = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  alarm_match u_dut (.*);

  function automatic bit refMatch();
    for (int k = 0; k < 4; k++) begin
      if (rptMask[k]) return 1'b1;
      if (timeNow[k*8 +: 8] != alarmSet[k*8 +: 8]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkPin();
    int eo, ev;
    if (onBattery) begin
      eo = (alarmEn && backupIrqEn) ? 1 : 0;
      ev = eo ? expFlag : 0;
    end else if (alarmEn) begin
      eo = 1; ev = expFlag;
    end else if (freqTestEn) begin
      eo = 1; ev = freqTestClk;
    end else begin
      eo = 0; ev = 0;
    end
    check(tag, irqOe, eo, "irqOe");
    check(tag, irqOut, ev, "irqOut");
  endtask

  // Inputs are set at the negedge before this call
  task automatic cycle();
    #1 checkPin();
    @(posedge clk);
    if (secTick && refMatch()) expFlag = 1;
    else if (flagsRead) expFlag = 0;
    @(negedge clk);
    check(tag, alarmFlag, expFlag, "alarmFlag");
  endtask

  task automatic pulse(logic tk, logic rd);
    secTick = tk; flagsRead = rd;
    cycle();
    secTick = 0; flagsRead = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1", alarmFlag, 0, "alarmFlag reset");
    checkPin();
    rstN = 1;
    @(negedge clk);
    alarmSet = 32'h15_12_30_45;
    timeNow  = 32'h01_00_00_00;
    // R3: everything masked, mismatching time still fires
    tag = "R3"; rptMask = 4'b1111; pulse(1, 0);
    // R6: sticky, then read clears
    tag = "R6"; pulse(0, 0); pulse(0, 0); pulse(0, 1); pulse(0, 0);
    // R4: seconds only
    tag = "R4"; rptMask = 4'b1110; pulse(1, 0);
    timeNow = 32'h00_00_00_45; pulse(1, 0); pulse(0, 1);
    rptMask = 4'b1100; pulse(1, 0);
    timeNow = 32'h00_00_30_45; pulse(1, 0); pulse(0, 1);
    rptMask = 4'b1000; pulse(1, 0);
    timeNow = 32'h00_12_30_45; pulse(1, 0); pulse(0, 1);
    rptMask = 4'b0000; pulse(1, 0);
    timeNow = 32'h15_12_30_45; pulse(1, 0); pulse(0, 1);
    // R2: match without tick does nothing; alarmEn low still sets
    tag = "R2"; alarmEn = 0; pulse(0, 0); pulse(0, 0); pulse(1, 0); pulse(0, 1);
    // R5: unlisted masks
    tag = "R5"; timeNow = 32'h00_00_00_00; rptMask = 4'b0101; pulse(1, 0); pulse(0, 1);
    rptMask = 4'b1010; pulse(1, 0);
    timeNow = 32'h00_00_00_45; pulse(1, 0); pulse(0, 1);
    rptMask = 4'b0100; timeNow = 32'h00_00_30_00; pulse(1, 0);
    timeNow = 32'h99_99_30_45; pulse(1, 0); pulse(0, 1);
    // R7: read collides with match
    tag = "R7"; rptMask = 4'b1111; pulse(1, 0); pulse(1, 1); pulse(0, 1);
    pulse(1, 1);
    // R8 R9 R10: pin ownership
    tag = "R10"; alarmEn = 0; freqTestEn = 1;
    freqTestClk = 0; pulse(0, 0); freqTestClk = 1; pulse(0, 0);
    tag = "R8"; alarmEn = 1; pulse(0, 0); pulse(0, 1); pulse(0, 0);
    tag = "R9"; onBattery = 1; backupIrqEn = 0; pulse(1, 0);
    backupIrqEn = 1; pulse(0, 0); alarmEn = 0; pulse(0, 0);
    onBattery = 0; freqTestEn = 0;
    // Random phase
    tag = "R2 R5 R8";
    for (int n = 0; n < 4000; n++) begin
      for (int k = 0; k < 4; k++) begin
        timeNow[k*8 +: 8]  = $urandom_range(1) ? 8'h59 : 8'h07;
        alarmSet[k*8 +: 8] = $urandom_range(1) ? 8'h59 : 8'h07;
      end
      rptMask     = 4'($urandom_range(15));
      secTick     = $urandom_range(2) == 0;
      flagsRead   = $urandom_range(3) == 0;
      alarmEn     = 1'($urandom_range(1));
      backupIrqEn = 1'($urandom_range(1));
      onBattery   = 1'($urandom_range(1));
      freqTestEn  = 1'($urandom_range(1));
      freqTestClk = 1'($urandom_range(1));
      cycle();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule